// File: doc/BRIEF.md
# Two-Player Number Guessing Game

The block runs a two-player guessing game from eight slide switches and two push buttons. The first player dials an eight-bit secret on the switches and presses the store button, which copies the switch value into an internal register. The second player dials a guess on the same switches and presses the check button. The block then compares the guess with the stored secret and latches the outcome on a result LED.

Each button passes through its own stability filter. The filtered level is then turned into a one-clock pulse on its rising edge, so a button that is held down acts only once. The sixteen-bit LED bus has three parts:

- The low byte follows the switches at all times.
- Bits 14 to 8 are held dark.
- Bit 15 is the result. It changes only when the check button is pressed.

A build parameter skips the filters so that simulations can use raw button levels.

Top module: `guess_game`

## Requirements
- R1: `led_o[7:0]` equals `sw_i` at all times, with no clock delay.
- R2: `led_o[14:8]` is always zero.
- R3: While `rst_ni` is low, the stored secret and the result bit `led_o[15]` are cleared to zero. After reset, a check with all switches at zero therefore drives `led_o[15]` to 1.
- R4: A press of `store_btn_i` loads the current `sw_i` into the secret register.
- R5: A press of `check_btn_i` sets `led_o[15]` to 1 when `sw_i` equals the stored secret, and to 0 otherwise.
- R6: Between check presses, `led_o[15]` keeps its value, even when the switches or the secret change.
- R7: A held button acts once, on its press. Switch changes made while the store button stays down do not alter the secret.
- R8: With filtering enabled, a raw button level that lasts fewer than `DB_CYCLES` clock cycles is ignored. A level held for `DB_CYCLES`+4 cycles or longer is accepted.
- R9: With `BYPASS_DB`=1, a raw button high for a single clock cycle acts, and `led_o[15]` is updated within two clock edges.
- R10: When a store press and a check press land in the same cycle, the check compares against the secret held before that store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_i | input | 8 | Slide switch value |
| store_btn_i | input | 1 | Raw store button (right) |
| check_btn_i | input | 1 | Raw check button (left) |
| led_o | output | 16 | LED bus: result, dark bits, switch mirror |

## Verification
A wrong secret is invisible until the next check press. At that press `led_o[15]` comes out inverted for exactly the guesses that separate the true secret from the corrupted one. The bench therefore sweeps all 256 guesses against several secrets, so that any single-bit error in the secret is exposed.

A stuck or spurious press pulse shows up differently. The result bit either does not move within two edges of a bypassed press, or it moves with no check press at all. A filter that accepts glitches shows up as a result change after a short raw pulse.

// File: rtl/guess_pkg.sv
package guess_pkg;
  localparam int unsigned SW_W  = 8;
  localparam int unsigned LED_W = 16;
  typedef logic [SW_W-1:0] sw_t;
endpackage

// File: rtl/btn_filter.sv
module btn_filter #(
  parameter int unsigned DB_CYCLES = 1_000_000,
  parameter bit          BYPASS    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o
);
  generate
    if (BYPASS) begin : g_byp
      assign lvl_o = raw_i;
    end else begin : g_flt
      localparam int unsigned CW = $clog2(DB_CYCLES + 1);
      localparam logic [CW-1:0] LIM = CW'(DB_CYCLES - 1);
      logic [1:0]    sync_q;
      logic [CW-1:0] cnt_q;
      logic          lvl_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '0;
          cnt_q  <= '0;
          lvl_q  <= 1'b0;
        end else begin
          sync_q <= {sync_q[0], raw_i};
          if (sync_q[1] == lvl_q) begin
            cnt_q <= '0;
          end else if (cnt_q == LIM) begin
            cnt_q <= '0;
            lvl_q <= sync_q[1];
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      assign lvl_o = lvl_q;

      AST_FLT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lvl_q) |-> lvl_q == $past(sync_q[1])) else $error("filter took foreign level"); // R8
      AST_FLT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIM) else $error("filter counter overrun"); // R8
    end
  endgenerate
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~prev_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o) else $error("pulse longer than one cycle"); // R7
endmodule

// File: rtl/guess_core.sv
module guess_core
  import guess_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sw_t  sw_i,
  input  logic store_i,
  input  logic check_i,
  output logic match_o
);
  sw_t  secret_q;
  logic match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secret_q <= '0;
      match_q  <= 1'b0;
    end else begin
      if (check_i) match_q  <= (sw_i == secret_q);  // old secret on a tie
      if (store_i) secret_q <= sw_i;
    end
  end

  assign match_o = match_q;

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_i |=> $stable(match_q)) else $error("flag moved without check"); // R6
  AST_SECRET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> $stable(secret_q)) else $error("secret moved without store"); // R4
  AST_STORE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> secret_q == $past(sw_i)) else $error("secret not loaded"); // R4
endmodule

// File: rtl/guess_game.sv
module guess_game
  import guess_pkg::*;
#(
  parameter int unsigned DB_CYCLES = 1_000_000,
  parameter bit          BYPASS_DB = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SW_W-1:0]  sw_i,
  input  logic             store_btn_i,
  input  logic             check_btn_i,
  output logic [LED_W-1:0] led_o
);
  localparam int unsigned NBTN  = 2;
  localparam int unsigned PAD_W = LED_W - 1 - SW_W;

  logic [NBTN-1:0] raw, lvl, pulse;
  logic            match;

  assign raw = {check_btn_i, store_btn_i};

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    btn_filter #(.DB_CYCLES(DB_CYCLES), .BYPASS(BYPASS_DB)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[i]),
      .lvl_o (lvl[i])
    );
    rise_pulse u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[i]),
      .pulse_o(pulse[i])
    );
  end

  guess_core u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sw_i   (sw_i),
    .store_i(pulse[0]),
    .check_i(pulse[1]),
    .match_o(match)
  );

  assign led_o = {match, {PAD_W{1'b0}}, sw_i};

  AST_LED_PAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o[LED_W-2:SW_W] == '0) else $error("pad bits lit"); // R2
  AST_RESULT_CHECKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_o[LED_W-1]) |-> $past(pulse[1])) else $error("result moved without check"); // R6
endmodule

// File: tb/tb_guess_game.sv
module tb_guess_game;
  localparam int unsigned DB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sw = '0;
  logic        st_r = 0, ck_r = 0, st_b = 0, ck_b = 0;
  logic [15:0] led, led_b;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  guess_game #(.DB_CYCLES(DB), .BYPASS_DB(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .store_btn_i(st_r), .check_btn_i(ck_r), .led_o(led));
  guess_game #(.DB_CYCLES(DB), .BYPASS_DB(1'b1)) dut_byp (
    .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .store_btn_i(st_b), .check_btn_i(ck_b), .led_o(led_b));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic press(input logic s, input logic c);
    @(negedge clk); st_r = s; ck_r = c;
    repeat (DB + 8) @(negedge clk);
    st_r = 0; ck_r = 0;
    repeat (DB + 8) @(negedge clk);
  endtask

  task automatic press_b(input logic s, input logic c);
    @(negedge clk); st_b = s; ck_b = c;
    @(negedge clk); st_b = 0; ck_b = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] secrets [4] = '{8'h00, 8'h5A, 8'hFF, 8'h81};
    repeat (3) @(negedge clk);
    chk("R3 reset result", {15'd0, led[15]}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: cleared secret matches zero guess
    sw = 8'h00; press(0, 1);
    chk("R3 zero secret", {15'd0, led[15]}, 16'd1);
    // R1 / R2 sweep
    for (int v = 0; v < 256; v++) begin
      sw = v[7:0]; #1;
      chk("R1 mirror", {8'd0, led[7:0]}, 16'(v));
      chk("R2 pad", {9'd0, led[14:8]}, 16'd0);
    end
    // R4 / R5 debounced
    sw = 8'h3C; press(1, 0);
    sw = 8'h3D; press(0, 1);
    chk("R5 mismatch", {15'd0, led[15]}, 16'd0);
    sw = 8'h3C; press(0, 1);
    chk("R4 R5 match", {15'd0, led[15]}, 16'd1);
    // R6: hold across switch and secret change
    sw = 8'h11; repeat (10) @(negedge clk);
    chk("R6 hold sw", {15'd0, led[15]}, 16'd1);
    press(1, 0);
    chk("R6 hold store", {15'd0, led[15]}, 16'd1);
    // R7: held store, switches change while down
    sw = 8'h77;
    @(negedge clk); st_r = 1;
    repeat (DB + 8) @(negedge clk);
    sw = 8'h99;
    repeat (DB + 8) @(negedge clk);
    st_r = 0;
    repeat (DB + 8) @(negedge clk);
    press(0, 1);
    chk("R7 held guess 99", {15'd0, led[15]}, 16'd0);
    sw = 8'h77; press(0, 1);
    chk("R7 held guess 77", {15'd0, led[15]}, 16'd1);
    // R8: short glitch ignored
    sw = 8'h00;
    @(negedge clk); ck_r = 1;
    repeat (DB - 2) @(negedge clk);
    ck_r = 0;
    repeat (DB + 8) @(negedge clk);
    chk("R8 glitch ignored", {15'd0, led[15]}, 16'd1);
    press(0, 1);
    chk("R8 long accepted", {15'd0, led[15]}, 16'd0);
    // R10: tie uses old secret (77)
    sw = 8'h77; press(1, 1);
    chk("R10 old secret", {15'd0, led[15]}, 16'd1);
    sw = 8'h12; press(1, 1);
    chk("R10 old secret mismatch", {15'd0, led[15]}, 16'd0);
    press(0, 1);
    chk("R10 new secret stored", {15'd0, led[15]}, 16'd1);
    // R9 / R5 exhaustive on bypass instance
    foreach (secrets[k]) begin
      sw = secrets[k]; press_b(1, 0);
      for (int g = 0; g < 256; g++) begin
        sw = g[7:0]; press_b(0, 1);
        chk("R9 R5 sweep", {15'd0, led_b[15]}, 16'(g[7:0] == secrets[k]));
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule